// File: doc/BRIEF.md
# Dual Auto-Modifying Data Pointer Unit

This block keeps two 16-bit address pointers for external data memory on an 8051-class core. One of them is active at any time. The active one is picked by a select bit and is presented on the output as the address for the next external-data move. A mode register gives each pointer its own post-access behaviour: hold, step up by one or step down by one. That step is applied only to the active pointer, and only when the core signals that an external-data move has completed.

Software reaches the mode register, the select bit and the two bytes of the active pointer through a byte-wide special-function-register port. Writes are registered. Reads are combinational. Other instructions that use the pointer, such as code-memory reads, are flagged on a separate input, and the unit ignores that flag. A block copy can therefore run as a loop of moves with no explicit pointer arithmetic.

Top module: `dptr_pair`

## Requirements
- R1: After reset both pointers are 0000h, the select bit is 0 (pointer 0 active) and the mode register reads 00h.
- R2: The mode register sits at SFR address 86h. Bits 1:0 hold the mode of pointer 0 and bits 3:2 hold the mode of pointer 1. Both fields read back what was written. Bits 7:4 always read 0 and ignore writes.
- R3: A move strobe (`xmove_done` high at a rising edge) changes only the active pointer. The other pointer keeps its value.
- R4: Mode code 10 adds one to the active pointer and code 11 subtracts one, both on the edge that samples the strobe. Code 00 and the reserved code 01 leave the pointer unchanged.
- R5: Stepping wraps modulo 2^16: FFFFh plus one gives 0000h, and 0000h minus one gives FFFFh.
- R6: `other_use` high without a move strobe and without an SFR write leaves both pointers and `ptr_out` unchanged.
- R7: An SFR write to a byte of the active pointer in the same cycle as a move strobe wins. That byte takes the written value, the other byte keeps its old value, and no step is applied.
- R8: The select bit is bit 0 of SFR 85h; bits 7:1 of 85h read 0. Addresses 82h and 83h read and write the low and high byte of the active pointer. `ptr_out` shows the active pointer combinationally, so it changes in the cycle after a select write.
- R9: A strobe in the same cycle as a write to the mode register or the select bit uses the mode and selection that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| xmove_done | input | 1 | Strobe: an external-data move completed |
| other_use | input | 1 | Another pointer-using instruction executed (no effect) |
| ptr_out | output | 16 | Value of the active pointer |

## Verification
The assertions check the following on every cycle:
- the inactive pointer stays put;
- the hold and reserved codes freeze the active pointer;
- both wrap edges produce the right value;
- a simultaneous byte write overrides the step;
- mode and select writes land;
- an idle or other-use cycle leaves the output stable.

Only the bench scenarios show the following:
- that multi-step runs reach the right end address for each mode and select combination;
- that the byte map, the read-back masking and the combinational output switch work from the port side;
- that a strobe coinciding with a mode or select write uses the old settings.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [1:0] {
    MD_HOLD = 2'b00,
    MD_RSVD = 2'b01,
    MD_INC  = 2'b10,
    MD_DEC  = 2'b11
  } step_mode_e;

  localparam logic [7:0] SFR_PLO  = 8'h82;
  localparam logic [7:0] SFR_PHI  = 8'h83;
  localparam logic [7:0] SFR_SEL  = 8'h85;
  localparam logic [7:0] SFR_MODE = 8'h86;
endpackage

// File: rtl/dptr_ctl.sv
module dptr_ctl
  import dptr_pkg::*;
#(
  parameter int NPTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [2*NPTR-1:0] mode_q,
  output logic              sel_q
);
  localparam int MW = 2 * NPTR;

  logic mode_wr, sel_wr;
  assign mode_wr = sfr_wr && (sfr_addr == SFR_MODE);
  assign sel_wr  = sfr_wr && (sfr_addr == SFR_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= sfr_wdata[MW-1:0];
      if (sel_wr)  sel_q  <= sfr_wdata[0];
    end
  end

  // R2: a mode write lands in the field register
  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode_q == $past(sfr_wdata[MW-1:0]));
  // R8: a select write lands
  p_sel_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(sfr_wdata[0]));
  // R9: without a write the settings stay as they are
  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_wr |=> ($stable(mode_q) && $stable(sel_q)));
endmodule

// File: rtl/dptr_slot.sv
module dptr_slot
  import dptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_me,
  input  logic [PTR_W/8-1:0] wr_byte,
  input  logic [7:0]         wdata,
  input  logic               move_stb,
  input  logic [1:0]         mode,
  output logic [PTR_W-1:0]   val
);
  localparam int NB = PTR_W / 8;

  function automatic logic [PTR_W-1:0] step_val(input logic [PTR_W-1:0] v,
                                                input logic [1:0] md);
    case (md)
      MD_INC:  step_val = v + 1'b1;
      MD_DEC:  step_val = v - 1'b1;
      default: step_val = v;
    endcase
  endfunction

  logic any_wr, do_step;
  logic [PTR_W-1:0] nxt;
  assign any_wr  = |wr_byte;
  assign do_step = sel_me && move_stb && !any_wr;

  always_comb begin
    nxt = val;
    if (any_wr) begin
      for (int b = 0; b < NB; b++)
        if (wr_byte[b]) nxt[8*b +: 8] = wdata;
    end else if (do_step) begin
      nxt = step_val(val, mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  // R3: an inactive, unwritten pointer keeps its value
  p_unsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_me && !any_wr) |=> $stable(val));
  // R4: hold and reserved codes freeze the pointer on a strobe
  p_hold_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && (mode == MD_HOLD || mode == MD_RSVD)) |=> $stable(val));
  // R5: wrap at the top and at the bottom
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && mode == MD_INC && val == '1) |=> val == '0);
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && mode == MD_DEC && val == '0) |=> val == '1);
  // R7: a byte write beats the strobe
  p_wr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (move_stb && wr_byte[0] && !wr_byte[NB-1]) |=>
      (val[7:0] == $past(wdata) && val[PTR_W-1:8] == $past(val[PTR_W-1:8])));
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
  import dptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sfr_addr,
  input  logic             sfr_wr,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             xmove_done,
  input  logic             other_use,
  output logic [PTR_W-1:0] ptr_out
);
  localparam int NPTR = 2;
  localparam int NB   = PTR_W / 8;
  localparam int MW   = 2 * NPTR;

  logic [MW-1:0]    mode_q;
  logic             sel_q;
  logic [PTR_W-1:0] ptr_val [NPTR];
  logic [NB-1:0]    wr_sel_byte;

  dptr_ctl #(.NPTR(NPTR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .mode_q(mode_q), .sel_q(sel_q)
  );

  always_comb begin
    wr_sel_byte = '0;
    wr_sel_byte[0]    = sfr_wr && (sfr_addr == SFR_PLO);
    wr_sel_byte[NB-1] = sfr_wr && (sfr_addr == SFR_PHI);
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_slot
    logic me;
    assign me = (sel_q == 1'(g));
    dptr_slot #(.PTR_W(PTR_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .sel_me(me),
      .wr_byte(wr_sel_byte & {NB{me}}), .wdata(sfr_wdata),
      .move_stb(xmove_done), .mode(mode_q[2*g +: 2]), .val(ptr_val[g])
    );
  end

  assign ptr_out = ptr_val[sel_q];

  always_comb begin
    case (sfr_addr)
      SFR_PLO:  sfr_rdata = ptr_out[7:0];
      SFR_PHI:  sfr_rdata = ptr_out[PTR_W-1 -: 8];
      SFR_SEL:  sfr_rdata = {7'b0, sel_q};
      SFR_MODE: sfr_rdata = 8'(mode_q);
      default:  sfr_rdata = 8'h00;
    endcase
  end

  // R6: no strobe and no write leaves the output alone, whatever other_use does
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmove_done && !sfr_wr) |=> $stable(ptr_out));
  // R2: reserved mode bits read as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SFR_MODE) |-> sfr_rdata[7:4] == 4'h0);
endmodule

// File: tb/dptr_pair_tb.sv
module dptr_pair_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic sfr_wr = 1'b0, xmove_done = 1'b0, other_use = 1'b0;
  logic [7:0] sfr_rdata;
  logic [15:0] ptr_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dptr_pair u_dut (.*);

  // vector: mode[44:37] sel[36] start[35:20] strobes[19:16] expect[15:0]
  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {8'h02, 1'b0, 16'h1234, 4'd3, 16'h1237},
    {8'h03, 1'b0, 16'h0002, 4'd5, 16'hFFFD},
    {8'h08, 1'b1, 16'hFFFE, 4'd3, 16'h0001},
    {8'h0C, 1'b1, 16'h8000, 4'd1, 16'h7FFF},
    {8'h01, 1'b0, 16'hABCD, 4'd4, 16'hABCD},
    {8'h00, 1'b1, 16'h5555, 4'd2, 16'h5555},
    {8'h0B, 1'b0, 16'h0010, 4'd2, 16'h000E},
    {8'h02, 1'b1, 16'h4000, 4'd3, 16'h4000}
  };

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one clock: drive after a falling edge, hold through the rising edge
  task automatic cyc(logic wr, logic [7:0] a, logic [7:0] d, logic stb, logic oth);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d; xmove_done = stb; other_use = oth;
    @(negedge clk);
    sfr_wr = 1'b0; xmove_done = 1'b0; other_use = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #1; d = sfr_rdata;
  endtask

  task automatic load(logic [15:0] v);
    wr(8'h83, v[15:8]);
    wr(8'h82, v[7:0]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptr_out", ptr_out, 16'h0000);
    rd(8'h86, r); chk("R1 mode", {8'h0, r}, 16'h0000);
    rd(8'h85, r); chk("R1 sel", {8'h0, r}, 16'h0000);
    wr(8'h85, 8'h01);
    chk("R1 ptr1", ptr_out, 16'h0000);
    wr(8'h85, 8'h00);

    // table: R4 R5 stepping under each mode and select
    for (int i = 0; i < NV; i++) begin
      wr(8'h85, {7'b0, VEC[i][36]});
      wr(8'h86, VEC[i][44:37]);
      load(VEC[i][35:20]);
      for (int k = 0; k < int'(VEC[i][19:16]); k++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
      chk($sformatf("R4/R5 vector %0d", i), ptr_out, VEC[i][15:0]);
    end

    // R2 read-back masking
    wr(8'h86, 8'hFF);
    rd(8'h86, r); chk("R2 mode readback", {8'h0, r}, 16'h000F);
    wr(8'h86, 8'h36);
    rd(8'h86, r); chk("R2 mode fields", {8'h0, r}, 16'h0006);

    // R3 / R8: only the active pointer steps; byte map and select
    wr(8'h86, 8'h0A);
    wr(8'h85, 8'h00); load(16'h0100);
    wr(8'h85, 8'h01); load(16'h0200);
    wr(8'h85, 8'h00);
    chk("R8 switch to ptr0", ptr_out, 16'h0100);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R3 active stepped", ptr_out, 16'h0102);
    rd(8'h82, r); chk("R8 low byte read", {8'h0, r}, 16'h0002);
    rd(8'h83, r); chk("R8 high byte read", {8'h0, r}, 16'h0001);
    wr(8'h85, 8'h01);
    chk("R3 inactive held", ptr_out, 16'h0200);
    rd(8'h85, r); chk("R8 sel read", {8'h0, r}, 16'h0001);

    // R6 other_use has no effect
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R6 other_use ignored", ptr_out, 16'h0200);

    // R7 write beats strobe
    load(16'h12FF);
    cyc(1'b1, 8'h82, 8'h77, 1'b1, 1'b0);
    chk("R7 low write wins", ptr_out, 16'h1277);
    cyc(1'b1, 8'h83, 8'h9A, 1'b1, 1'b0);
    chk("R7 high write wins", ptr_out, 16'h9A77);

    // R9 strobe together with a mode write uses the old mode
    wr(8'h86, 8'h00);
    wr(8'h85, 8'h00); load(16'h0050);
    cyc(1'b1, 8'h86, 8'h02, 1'b1, 1'b0);
    chk("R9 old mode used", ptr_out, 16'h0050);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R9 new mode next", ptr_out, 16'h0051);
    // R9 strobe together with a select write steps the old pointer
    wr(8'h86, 8'h0A);
    cyc(1'b1, 8'h85, 8'h01, 1'b1, 1'b0);
    chk("R9 new sel shown", ptr_out, 16'h9A77);
    wr(8'h85, 8'h00);
    chk("R9 old sel stepped", ptr_out, 16'h0052);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule